// File: doc/BRIEF.md
# Byte-Packing Data FIFO Engine

This block moves a programmed number of bytes between a word FIFO (16 entries of 32 bits by default) and a byte-wide card data port, in either direction. Software first loads a 16-bit byte length. A write to the 8-bit transfer-control register with its enable bit set copies that length into a byte counter and starts the transfer. The direction bit then picks one of two paths. In the receive direction, the engine packs bytes from the card into words and pushes them into the FIFO, where the host pops them. In the transmit direction, the host pushes words, and the engine pops each one and sends it out as bytes.

The card side has one valid/ready byte channel for each direction, and the engine moves at most one byte per clock. The engine reports a set of FIFO status flags that depend on the direction, two sticky end-of-transfer flags, and the number of words still to move. It turns itself off once the byte counter and the FIFO are both empty.

Top module: `byte_pack_engine`

## Requirements
- R1: The FIFO holds DEPTH (16) words of 32 bits. A push when the FIFO is full is ignored. A host pop when the FIFO is empty changes nothing, and `fifo_rdata_o` reads zero whenever the FIFO is empty.
- R2: The control register keeps 8 bits: bit 0 is enable and bit 1 is direction (1 = card to host); the other bits are stored only. The length register keeps 16 bits. A control write with bit 0 set loads the byte counter from the length register on the same edge. A control write with bit 0 clear stores the bits and starts nothing.
- R3: In the receive direction, byte k of a word goes to bits [8k+7:8k], starting at bits [7:0]. A word is pushed after its fourth byte. A partial word, with its unused lanes at zero, is pushed when the counter reaches zero.
- R4: In the transmit direction, the engine pops a word and sends it low byte first, one byte per handshake, and decrements the counter for each byte. Bytes left in the last word when the counter reaches zero are not sent.
- R5: Status bit 8 (data end) and status bit 10 (block end) are set on the clock edge after the counter is zero while the engine is enabled. Both stay set until the next control write that has bit 0 set, which clears them.
- R6: While enabled, if the counter is zero and the FIFO is empty, control bit 0 clears on the next edge. The other control bits keep their values.
- R7: While busy (enabled, and the counter or the FIFO is non-empty), the engine reports five flags: active; empty (level 0); data available (level above 0); full (level 16); and half-empty (level at most 8) in the transmit direction or half-full (level at least 8) in the receive direction.
- R8: Receive flags are bits 13 (active), 15 (half-full), 17 (full), 19 (empty) and 21 (available). Transmit flags are bits 12, 14, 16, 18 and 20 in the same order. Only the set for the current direction can be non-zero, and all of bits 21:12 read zero when the engine is not busy.
- R9: `words_left_o` equals (counter + 3) >> 2.
- R10: A host FIFO write while the byte counter is zero is dropped.
- R11: The engine takes at most one byte per clock. `rx_ready_o` is low while the FIFO is full, the counter is zero or the direction is transmit. Each accepted byte lowers the counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_wr_i | input | 1 | Write strobe for the byte length |
| len_wdata_i | input | 16 | Byte length to store |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| ctrl_wdata_i | input | 8 | Control value (bit 0 enable, bit 1 direction) |
| fifo_wr_i | input | 1 | Host push strobe |
| fifo_wdata_i | input | 32 | Host push word |
| fifo_rd_i | input | 1 | Host pop strobe |
| fifo_rdata_o | output | 32 | FIFO head word, zero when empty |
| rx_valid_i | input | 1 | Card byte offered |
| rx_data_i | input | 8 | Card byte |
| rx_ready_o | output | 1 | Engine accepts a card byte |
| tx_valid_o | output | 1 | Engine offers a byte to the card |
| tx_data_o | output | 8 | Byte to the card |
| tx_ready_i | input | 1 | Card accepts the byte |
| ctrl_o | output | 8 | Control register |
| count_o | output | 16 | Remaining byte count |
| words_left_o | output | 16 | Remaining words, rounded up |
| status_o | output | 22 | Status flags |

## Verification
A corrupted byte lane or packing position shows up in the next word the host pops. In the receive direction this is within four bytes, and for a short final word it is at the last byte. A wrong FIFO level changes status bits 14–21 at the very next sample. The level sweep passes through the boundaries at 0, 8, 9 and 16 words, so an off-by-one in any threshold flips a flag there. If the counter or the auto-disable logic fails, `count_o`, `words_left_o` or control bit 0 goes wrong one edge after the byte or pop that caused it. A leftover transmit byte shows up as `tx_valid_o` staying high after the counter reaches zero.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

  localparam int ST_W        = 22;
  localparam int ST_DEND     = 8;
  localparam int ST_BEND     = 10;
  localparam int ST_TX_ACT   = 12;
  localparam int ST_RX_ACT   = 13;
  localparam int ST_TX_HALF  = 14;
  localparam int ST_RX_HALF  = 15;
  localparam int ST_TX_FULL  = 16;
  localparam int ST_RX_FULL  = 17;
  localparam int ST_TX_EMPTY = 18;
  localparam int ST_RX_EMPTY = 19;
  localparam int ST_TX_AVAIL = 20;
  localparam int ST_RX_AVAIL = 21;

  localparam int CTL_EN  = 0;
  localparam int CTL_DIR = 1;

  localparam logic [ST_W-1:0] TX_FLAG_MASK = 22'h15_5000;
  localparam logic [ST_W-1:0] RX_FLAG_MASK = 22'h2A_A000;

  // Direction-qualified FIFO flags; all zero when not busy.
  function automatic logic [ST_W-1:0] fifo_flags(input logic busy, input logic dir,
                                                 input int unsigned level,
                                                 input int unsigned depth);
    logic [ST_W-1:0] f;
    f = '0;
    if (busy) begin
      if (dir) begin
        f[ST_RX_ACT]   = 1'b1;
        f[ST_RX_EMPTY] = (level == 0);
        f[ST_RX_AVAIL] = (level != 0);
        f[ST_RX_FULL]  = (level == depth);
        f[ST_RX_HALF]  = (level >= depth / 2);
      end else begin
        f[ST_TX_ACT]   = 1'b1;
        f[ST_TX_EMPTY] = (level == 0);
        f[ST_TX_AVAIL] = (level != 0);
        f[ST_TX_FULL]  = (level == depth);
        f[ST_TX_HALF]  = (level <= depth / 2);
      end
    end
    return f;
  endfunction

  // Words still to move, rounded up.
  function automatic logic [31:0] words_left(input logic [31:0] bytes, input int unsigned lanes);
    return (bytes + 32'(lanes) - 32'd1) / 32'(lanes);
  endfunction

endpackage

// File: rtl/bpk_word_fifo.sv
module bpk_word_fifo #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic              push_ok, pop_ok, is_empty, is_full;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign is_empty = (level_q == '0);
  assign is_full  = (level_q == LVL_W'(DEPTH));
  assign push_ok  = push_i && !is_full;
  assign pop_ok   = pop_i && !is_empty;
  assign rdata_o  = is_empty ? '0 : mem[rd_ptr_q];
  assign level_o  = level_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      if (push_ok && !pop_ok)      level_q <= level_q + LVL_W'(1);
      else if (pop_ok && !push_ok) level_q <= level_q - LVL_W'(1);
    end
  end

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH));

  p_full_push_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && is_full) |=> (level_q == LVL_W'(DEPTH)));

  p_empty_pop_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && is_empty) |=> (level_q == '0));

endmodule

// File: rtl/bpk_rx_pack.sv
module bpk_rx_pack #(
  parameter int WORD_W = 32,
  parameter int LANES  = WORD_W / 8,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              act_i,
  input  logic              last_i,
  input  logic              room_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              take_o,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q;
  logic [LANE_W-1:0] lane_q;
  logic              lane_top;

  function automatic logic [WORD_W-1:0] lane_insert(input logic [WORD_W-1:0] w,
                                                    input logic [7:0] b,
                                                    input logic [LANE_W-1:0] lane);
    logic [WORD_W-1:0] r;
    r = w;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LANE_W'(i)) r[i*8 +: 8] = b;
    end
    return r;
  endfunction

  assign rx_ready_o = act_i && room_i;
  assign take_o     = rx_valid_i && rx_ready_o;
  assign lane_top   = (lane_q == LANE_W'(LANES - 1));
  assign word_o     = lane_insert(acc_q, rx_data_i, lane_q);
  assign push_o     = take_o && (lane_top || last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (clr_i) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (take_o) begin
      if (push_o) begin
        acc_q  <= '0;
        lane_q <= '0;
      end else begin
        acc_q  <= word_o;
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end

  p_push_has_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> room_i);

  p_partial_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && last_i && !clr_i) |=> (lane_q == '0 && acc_q == '0));

endmodule

// File: rtl/bpk_tx_unpack.sv
module bpk_tx_unpack #(
  parameter int WORD_W = 32,
  parameter int LANES  = WORD_W / 8,
  parameter int NB_W   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic              act_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_word_i,
  input  logic              tx_ready_i,
  output logic              pop_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              take_o
);
  logic [WORD_W-1:0] hold_q;
  logic [NB_W-1:0]   nb_q;
  logic              hold_empty;

  assign hold_empty = (nb_q == '0);
  assign pop_o      = act_i && hold_empty && !fifo_empty_i;
  assign tx_valid_o = act_i && !hold_empty;
  assign tx_data_o  = hold_q[7:0];
  assign take_o     = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      nb_q   <= '0;
    end else if (clr_i || done_i) begin
      hold_q <= '0;
      nb_q   <= '0;
    end else if (pop_o) begin
      hold_q <= fifo_word_i;
      nb_q   <= NB_W'(LANES);
    end else if (take_o) begin
      hold_q <= hold_q >> 8;
      nb_q   <= nb_q - NB_W'(1);
    end
  end

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !clr_i) |=> (!hold_empty && $stable(tx_data_o)));

  p_tx_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !clr_i && !done_i) |=> (tx_data_o == $past(hold_q[15:8])));

endmodule

// File: rtl/byte_pack_engine.sv
module byte_pack_engine
  import bpk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_wr_i,
  input  logic [LEN_W-1:0]  len_wdata_i,
  input  logic              ctrl_wr_i,
  input  logic [CTL_W-1:0]  ctrl_wdata_i,
  input  logic              fifo_wr_i,
  input  logic [WORD_W-1:0] fifo_wdata_i,
  input  logic              fifo_rd_i,
  output logic [WORD_W-1:0] fifo_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic [LEN_W-1:0]  count_o,
  output logic [LEN_W-1:0]  words_left_o,
  output logic [ST_W-1:0]   status_o
);
  localparam int LANES = WORD_W / 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [CTL_W-1:0]  ctrl_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              dend_q, bend_q;

  logic              start, en, dir, cnt_nz, cnt_last;
  logic              rx_act, tx_act, room, fifo_empty, busy;
  logic [LVL_W-1:0]  level;
  logic [WORD_W-1:0] head_word, rx_word, push_word;
  logic              rx_push, rx_take, tx_pop, tx_take;
  logic              host_push, host_pop, push, pop, byte_take;

  assign start      = ctrl_wr_i && ctrl_wdata_i[CTL_EN];
  assign en         = ctrl_q[CTL_EN];
  assign dir        = ctrl_q[CTL_DIR];
  assign cnt_nz     = (cnt_q != '0);
  assign cnt_last   = (cnt_q == LEN_W'(1));
  assign rx_act     = en && dir && cnt_nz;
  assign tx_act     = en && !dir && cnt_nz;
  assign room       = (level < LVL_W'(DEPTH));
  assign fifo_empty = (level == '0);
  assign busy       = en && (cnt_nz || !fifo_empty);

  bpk_rx_pack #(.WORD_W(WORD_W), .LANES(LANES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start),
    .act_i      (rx_act),
    .last_i     (cnt_last),
    .room_i     (room),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .take_o     (rx_take),
    .push_o     (rx_push),
    .word_o     (rx_word)
  );

  bpk_tx_unpack #(.WORD_W(WORD_W), .LANES(LANES)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (start),
    .done_i       (!cnt_nz),
    .act_i        (tx_act),
    .fifo_empty_i (fifo_empty),
    .fifo_word_i  (head_word),
    .tx_ready_i   (tx_ready_i),
    .pop_o        (tx_pop),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .take_o       (tx_take)
  );

  // Engine traffic wins over the host on the shared FIFO ports.
  assign host_push = fifo_wr_i && cnt_nz && !rx_push;
  assign host_pop  = fifo_rd_i && !tx_pop;
  assign push      = rx_push || host_push;
  assign pop       = tx_pop || host_pop;
  assign push_word = rx_push ? rx_word : fifo_wdata_i;
  assign byte_take = rx_take || tx_take;

  bpk_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LVL_W(LVL_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .wdata_i (push_word),
    .pop_i   (pop),
    .rdata_o (head_word),
    .level_o (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      dend_q <= 1'b0;
      bend_q <= 1'b0;
    end else begin
      if (len_wr_i) len_q <= len_wdata_i;

      if (ctrl_wr_i)                        ctrl_q <= ctrl_wdata_i;
      else if (en && !cnt_nz && fifo_empty) ctrl_q[CTL_EN] <= 1'b0;

      if (start)          cnt_q <= len_q;
      else if (byte_take) cnt_q <= cnt_q - LEN_W'(1);

      if (start) begin
        dend_q <= 1'b0;
        bend_q <= 1'b0;
      end else if (en && !cnt_nz) begin
        dend_q <= 1'b1;
        bend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o          = fifo_flags(busy, dir, 32'(level), DEPTH);
    status_o[ST_DEND] = dend_q;
    status_o[ST_BEND] = bend_q;
  end

  assign fifo_rdata_o = head_word;
  assign ctrl_o       = ctrl_q;
  assign count_o      = cnt_q;
  assign words_left_o = LEN_W'(words_left(32'(cnt_q), LANES));

  p_one_byte_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr_i && cnt_nz) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - LEN_W'(1)));

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !len_wr_i) |=> (count_o == $past(len_q)));

  p_auto_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_nz && fifo_empty && !ctrl_wr_i) |=> !ctrl_o[CTL_EN]);

  p_end_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_nz && !ctrl_wr_i) |=> (status_o[ST_DEND] && status_o[ST_BEND]));

  p_dir_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> ((status_o & TX_FLAG_MASK) == '0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> ((status_o & (TX_FLAG_MASK | RX_FLAG_MASK)) == '0));

  p_no_dual_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_take && tx_take));

endmodule

// File: tb/byte_pack_engine_tb.sv
`timescale 1ns/1ps
module byte_pack_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 1'b0;
  logic [15:0] len_wdata = '0;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic        fifo_wr = 1'b0;
  logic [31:0] fifo_wdata = '0;
  logic        fifo_rd = 1'b0;
  logic [31:0] fifo_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic [7:0]  ctrl_o;
  logic [15:0] count_o;
  logic [15:0] words_left_o;
  logic [21:0] status_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [21:0] END_BITS = 22'h000500;

  always #4 clk = ~clk;

  byte_pack_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .len_wr_i(len_wr), .len_wdata_i(len_wdata),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .fifo_wr_i(fifo_wr), .fifo_wdata_i(fifo_wdata),
    .fifo_rd_i(fifo_rd), .fifo_rdata_o(fifo_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .ctrl_o(ctrl_o), .count_o(count_o), .words_left_o(words_left_o),
    .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected busy flags: receive set sits one bit above the transmit set.
  function automatic logic [21:0] exp_fl(input bit rxdir, input int lvl);
    logic [21:0] v;
    int b;
    v = '0;
    b = rxdir ? 13 : 12;
    v[b]     = 1'b1;
    v[b + 4] = (lvl == 16);
    v[b + 6] = (lvl == 0);
    v[b + 8] = (lvl > 0);
    if (rxdir) v[15] = (lvl >= 8);
    else       v[14] = (lvl <= 8);
    return v;
  endfunction

  function automatic logic [7:0] rx_byte(input int len, input int n);
    return 8'((len * 37 + n * 11 + 5) & 255);
  endfunction

  function automatic logic [31:0] tx_word(input int len, input int w);
    return 32'(len * 32'h0103_0507 + w * 32'h1122_3344 + 9);
  endfunction

  task automatic wr_len(input int v);
    len_wr = 1'b1; len_wdata = 16'(v);
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic host_push(input logic [31:0] w);
    fifo_wr = 1'b1; fifo_wdata = w;
    @(negedge clk);
    fifo_wr = 1'b0;
  endtask

  task automatic host_pop(input string req, input logic [31:0] exp);
    chk(req, fifo_rdata, exp);
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    for (int t = 0; t < 64 && !rx_ready; t++) @(negedge clk);
    chk("R11 rx_ready before byte", 32'(rx_ready), 32'd1);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_get(output logic [7:0] b);
    for (int t = 0; t < 64 && !tx_valid; t++) @(negedge clk);
    chk("R4 tx_valid before byte", 32'(tx_valid), 32'd1);
    b = tx_data;
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic run_rx(input int len);
    int lvl, rem, nw;
    logic [31:0] w;
    wr_len(len);
    wr_ctrl(8'h03);
    chk("R2 counter loaded", 32'(count_o), 32'(len));
    chk("R5 R8 start status", 32'(status_o), 32'(exp_fl(1'b1, 0)));
    for (int n = 0; n < len; n++) begin
      rx_send(rx_byte(len, n));
      rem = len - n - 1;
      lvl = (n + 1) / 4 + (((rem == 0) && ((n + 1) % 4 != 0)) ? 1 : 0);
      chk("R11 count per byte", 32'(count_o), 32'(rem));
      chk("R9 words left", 32'(words_left_o), 32'((rem + 3) >> 2));
      chk("R7 R8 rx flags", 32'(status_o), 32'(exp_fl(1'b1, lvl)));
    end
    @(negedge clk);
    chk("R5 end flags", 32'(status_o & END_BITS), 32'(END_BITS));
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      w = '0;
      for (int i = 4 * k; i < len && i < 4 * k + 4; i++)
        w = w | (32'(rx_byte(len, i)) << (8 * (i - 4 * k)));
      host_pop("R3 packed word", w);
    end
    @(negedge clk);
    chk("R6 auto disable rx", 32'(ctrl_o), 32'h02);
    chk("R8 idle status rx", 32'(status_o), 32'(END_BITS));
  endtask

  task automatic run_tx(input int len);
    int nw;
    logic [7:0] b;
    logic [31:0] w;
    wr_len(len);
    wr_ctrl(8'h01);
    chk("R7 R8 tx start flags", 32'(status_o), 32'(exp_fl(1'b0, 0)));
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) host_push(tx_word(len, k));
    for (int i = 0; i < len; i++) begin
      tx_get(b);
      w = tx_word(len, i / 4);
      chk("R4 tx byte order", 32'(b), 32'(w[8 * (i % 4) +: 8]));
      chk("R4 count per byte", 32'(count_o), 32'(len - i - 1));
    end
    chk("R4 no leftover byte", 32'(tx_valid), 32'd0);
    @(negedge clk);
    chk("R6 auto disable tx", 32'(ctrl_o), 32'h00);
    chk("R5 tx end status", 32'(status_o), 32'(END_BITS));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R2 reset ctrl", 32'(ctrl_o), 32'd0);
    chk("R2 reset count", 32'(count_o), 32'd0);
    chk("R9 reset words", 32'(words_left_o), 32'd0);
    chk("R8 reset status", 32'(status_o), 32'd0);
    chk("R11 reset rx_ready", 32'(rx_ready), 32'd0);
    chk("R4 reset tx_valid", 32'(tx_valid), 32'd0);

    host_pop("R1 empty pop zero", 32'd0);
    chk("R1 empty pop still zero", fifo_rdata, 32'd0);

    // R10: push with counter zero, then start transmit; nothing may come out.
    host_push(32'h1234_5678);
    wr_len(4);
    wr_ctrl(8'h01);
    repeat (3) @(negedge clk);
    chk("R10 dropped push no tx", 32'(tx_valid), 32'd0);
    chk("R10 dropped push empty flags", 32'(status_o), 32'(exp_fl(1'b0, 0)));
    host_push(32'hA1B2_C3D4);
    for (int i = 0; i < 4; i++) begin
      tx_get(b);
      w = 32'hA1B2_C3D4;
      chk("R4 first tx word", 32'(b), 32'(w[8 * i +: 8]));
    end
    @(negedge clk);
    chk("R6 first tx off", 32'(ctrl_o), 32'h00);

    // R2: enable clear stores bits only.
    wr_len(9);
    wr_ctrl(8'hF2);
    chk("R2 ctrl stored", 32'(ctrl_o), 32'hF2);
    chk("R2 no start", 32'(count_o), 32'd0);
    chk("R8 not busy", 32'(status_o & 22'h3F_F000), 32'd0);

    // Zero-length start.
    wr_len(0);
    wr_ctrl(8'h03);
    chk("R5 flags cleared on start", 32'(status_o), 32'd0);
    @(negedge clk);
    chk("R6 zero length off", 32'(ctrl_o), 32'h02);
    chk("R5 zero length end", 32'(status_o), 32'(END_BITS));

    for (int len = 1; len <= 9; len++) run_rx(len);
    run_rx(15); run_rx(16); run_rx(17); run_rx(63);
    for (int len = 1; len <= 9; len++) run_tx(len);
    run_tx(33);

    // Receive into a full FIFO.
    wr_len(70);
    wr_ctrl(8'h03);
    for (int n = 0; n < 64; n++) rx_send(rx_byte(70, n));
    chk("R7 rx full flags", 32'(status_o), 32'(exp_fl(1'b1, 16)));
    chk("R11 rx_ready low when full", 32'(rx_ready), 32'd0);
    host_push(32'hDEAD_BEEF);
    rx_valid = 1'b1; rx_data = 8'h55;
    repeat (3) @(negedge clk);
    rx_valid = 1'b0;
    chk("R1 full holds count", 32'(count_o), 32'd6);
    for (int k = 0; k < 16; k++) begin
      w = '0;
      for (int i = 0; i < 4; i++) w = w | (32'(rx_byte(70, 4 * k + i)) << (8 * i));
      host_pop("R1 R3 full drain word", w);
    end
    for (int n = 64; n < 70; n++) rx_send(rx_byte(70, n));
    w = '0;
    for (int i = 0; i < 4; i++) w = w | (32'(rx_byte(70, 64 + i)) << (8 * i));
    host_pop("R3 after full word", w);
    w = 32'(rx_byte(70, 68)) | (32'(rx_byte(70, 69)) << 8);
    host_pop("R3 after full partial", w);
    @(negedge clk);
    chk("R6 full case off", 32'(ctrl_o), 32'h02);

    // Transmit half-empty boundary at 9 and 8 words.
    wr_len(40);
    wr_ctrl(8'h01);
    for (int k = 0; k < 10; k++) host_push(tx_word(40, k));
    chk("R7 tx level 9 flags", 32'(status_o), 32'(exp_fl(1'b0, 9)));
    for (int i = 0; i < 40; i++) begin
      tx_get(b);
      w = tx_word(40, i / 4);
      chk("R4 long tx byte", 32'(b), 32'(w[8 * (i % 4) +: 8]));
      chk("R9 tx words left", 32'(words_left_o), 32'((40 - i - 1 + 3) >> 2));
      if (i == 3) begin
        @(negedge clk);
        chk("R7 tx level 8 flags", 32'(status_o), 32'(exp_fl(1'b0, 8)));
      end
    end
    @(negedge clk);
    chk("R6 long tx off", 32'(ctrl_o), 32'h00);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule